// File: doc/BRIEF.md
# Flash Block Write-Protection Unit

This unit decides, for a serial NOR flash whose array is split into 512 equal 64 KiB blocks, whether a program or erase request may go ahead. It holds a four-bit protection level, a direction bit and a status-lock bit. From these it computes a protected window that grows by powers of two from one end of the array. A request whose block falls inside the window is refused. Any other request is accepted. Each outcome is reported as a one-cycle pulse on the clock edge after the request.

The same unit guards its own status bits. A write to them is refused while the status-lock bit is set and the hardware write-protect pin is held low. When the device is operating in a four-wire data mode, that pin carries data, so the pin guard is switched off. The command decoder and the storage array sit outside this unit. The decoder presents a byte address together with strobes, and uses the grant and deny pulses to carry out or drop the operation.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset, the protection level, direction bit and status-lock bit all read 0, and neither grant nor deny is asserted.
- R2: A status write that is not refused loads `sr_wdata[3:0]` into the level, `sr_wdata[4]` into the direction bit and `sr_wdata[5]` into the status-lock bit. The new values appear on the status outputs after the next rising clock edge.
- R3: A status write is refused, leaving all three status fields unchanged, when the status-lock bit is 1, `wp_n` is 0 and `quad_mode` is 0.
- R4: While `quad_mode` is 1, a status write is accepted whatever the values of `wp_n` and the status-lock bit.
- R5: At level 0, a request to any block is granted.
- R6: At a level L from 1 to 9, with the direction bit at 1, the blocks from 512-2^(L-1) to 511 are denied and all lower blocks are granted.
- R7: At a level L from 1 to 9, with the direction bit at 0, the blocks from 0 to 2^(L-1)-1 are denied and all higher blocks are granted.
- R8: At levels 10 to 15, a request to any block is denied, for either value of the direction bit.
- R9: Each cycle with `pe_req` high produces exactly one pulse, on grant or on deny, one cycle later and lasting one cycle. The block is `addr[24:16]`, and `addr[15:0]` has no effect on the result.
- R10: A request, whether granted or denied, leaves the status outputs unchanged.
- R11: When a request and a status write occur in the same cycle, the request is judged against the status held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 25 | Byte address of the program or erase target |
| pe_req | input | 1 | Program or erase request strobe |
| sr_wr | input | 1 | Status write strobe |
| sr_wdata | input | 6 | Status write data: [3:0] level, [4] direction, [5] lock |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| quad_mode | input | 1 | Four-wire data mode active; disables the pin guard |
| grant | output | 1 | One-cycle pulse: request allowed |
| deny | output | 1 | One-cycle pulse: request refused |
| bp_level | output | 4 | Current protection level |
| tb_sel | output | 1 | Current direction bit (1 = protect from the top end) |
| srwd | output | 1 | Current status-lock bit |

## Verification
A corrupted level or direction bit moves the protected window edge. It shows up as a wrong grant or deny on the first request that targets a block next to that edge, one cycle after the request. Because every level and direction combination is swept over all 512 blocks, any off-by-one in a threshold is caught within that sweep. A wrong decision on the write guard leaves the status outputs either changed or frozen when they should not be, and this is visible on the cycle right after the write strobe.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam int unsigned LVL_W = 4;

  typedef struct packed {
    logic             srwd;
    logic             tb;
    logic [LVL_W-1:0] bp;
  } wp_status_t;

  localparam int unsigned STAT_W = $bits(wp_status_t);

  // Window test: level 0 is open, levels above blk_w cover the array,
  // otherwise 2^(lvl-1) blocks from the end picked by tb.
  function automatic logic blk_protected(input logic [31:0] blk,
                                         input logic [LVL_W-1:0] lvl,
                                         input logic tb,
                                         input int unsigned blk_w);
    logic [31:0] cnt;
    logic [31:0] nblk;
    if (lvl == '0) return 1'b0;
    if (32'(lvl) > blk_w) return 1'b1;
    cnt  = 32'd1 << (lvl - 1'b1);
    nblk = 32'd1 << blk_w;
    return tb ? (blk >= nblk - cnt) : (blk < cnt);
  endfunction

endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
  import flash_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_wr,
  input  wp_status_t wdata,
  input  logic       wp_n,
  input  logic       quad_mode,
  output wp_status_t status_q,
  output logic       wr_blocked,
  output logic       wr_taken
);

  logic pin_guard_on;

  assign pin_guard_on = ~quad_mode & ~wp_n;
  assign wr_blocked   = sr_wr & status_q.srwd & pin_guard_on;
  assign wr_taken     = sr_wr & ~wr_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (wr_taken) begin
      status_q <= wdata;
    end
  end

endmodule

// File: rtl/wp_range_check.sv
module wp_range_check
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned BLK_W  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  wp_status_t        status,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              hit
);

  assign blk_idx = addr[ADDR_W-1 -: BLK_W];
  assign hit     = blk_protected(32'(blk_idx), status.bp, status.tb, BLK_W);

endmodule

// File: rtl/wp_decision.sv
module wp_decision (
  input  logic clk,
  input  logic rst_n,
  input  logic pe_req,
  input  logic hit,
  output logic grant,
  output logic deny
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= pe_req & ~hit;
      deny  <= pe_req & hit;
    end
  end

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned BLK_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pe_req,
  input  logic              sr_wr,
  input  logic [STAT_W-1:0] sr_wdata,
  input  logic              wp_n,
  input  logic              quad_mode,
  output logic              grant,
  output logic              deny,
  output logic [LVL_W-1:0]  bp_level,
  output logic              tb_sel,
  output logic              srwd
);

  wp_status_t       status_q;
  wp_status_t       wdata_s;
  logic             wr_blocked;
  logic             wr_taken;
  logic [BLK_W-1:0] blk_idx;
  logic             hit;

  assign wdata_s = wp_status_t'(sr_wdata);

  wp_status_reg u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr      (sr_wr),
    .wdata      (wdata_s),
    .wp_n       (wp_n),
    .quad_mode  (quad_mode),
    .status_q   (status_q),
    .wr_blocked (wr_blocked),
    .wr_taken   (wr_taken)
  );

  wp_range_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_range (
    .addr    (addr),
    .status  (status_q),
    .blk_idx (blk_idx),
    .hit     (hit)
  );

  wp_decision u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .pe_req (pe_req),
    .hit    (hit),
    .grant  (grant),
    .deny   (deny)
  );

  assign bp_level = status_q.bp;
  assign tb_sel   = status_q.tb;
  assign srwd     = status_q.srwd;

endmodule

// File: rtl/flash_wp_unit_chk.sv
module flash_wp_unit_chk #(
  parameter int unsigned BLK_W = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pe_req,
  input logic       sr_wr,
  input logic [5:0] sr_wdata,
  input logic       quad_mode,
  input logic       grant,
  input logic       deny,
  input logic [3:0] bp_level,
  input logic       tb_sel,
  input logic       srwd,
  input logic       wr_blocked
);

  logic [5:0] stat;
  assign stat = {srwd, tb_sel, bp_level};

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));
  a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |=> (grant ^ deny));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_req |=> (!grant && !deny));
  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(stat));
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && !wr_blocked) |=> (stat == $past(sr_wdata)));
  a_r4_quad_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && quad_mode) |-> !wr_blocked);
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr |=> $stable(stat));
  a_r5_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && bp_level == 4'd0) |=> grant);
  a_r8_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && 32'(bp_level) > BLK_W) |=> deny);

endmodule

bind flash_wp_unit flash_wp_unit_chk #(.BLK_W(BLK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pe_req     (pe_req),
  .sr_wr      (sr_wr),
  .sr_wdata   (sr_wdata),
  .quad_mode  (quad_mode),
  .grant      (grant),
  .deny       (deny),
  .bp_level   (bp_level),
  .tb_sel     (tb_sel),
  .srwd       (srwd),
  .wr_blocked (wr_blocked)
);

// File: tb/flash_wp_unit_bench.sv
module flash_wp_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] addr = '0;
  logic        pe_req = 1'b0;
  logic        sr_wr = 1'b0;
  logic [5:0]  sr_wdata = '0;
  logic        wp_n = 1'b1;
  logic        quad_mode = 1'b0;
  logic        grant, deny;
  logic [3:0]  bp_level;
  logic        tb_sel, srwd;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_unit u_flash_wp_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .pe_req(pe_req), .sr_wr(sr_wr),
    .sr_wdata(sr_wdata), .wp_n(wp_n), .quad_mode(quad_mode), .grant(grant),
    .deny(deny), .bp_level(bp_level), .tb_sel(tb_sel), .srwd(srwd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Expected deny, written as an explicit window [lo, hi].
  function automatic bit want_deny(int lvl, bit tb, int blk);
    int size, lo, hi;
    if (lvl == 0) return 0;
    size = (lvl >= 10) ? 512 : (1 << (lvl - 1));
    lo = tb ? 512 - size : 0;
    hi = tb ? 511 : size - 1;
    return (blk >= lo) && (blk <= hi);
  endfunction

  task automatic write_status(input logic [5:0] d);
    @(negedge clk);
    sr_wr = 1'b1;
    sr_wdata = d;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  // Returns {grant,deny} seen one cycle after the request.
  task automatic request(input logic [24:0] a, output logic [1:0] gd);
    @(negedge clk);
    pe_req = 1'b1;
    addr = a;
    @(negedge clk);
    pe_req = 1'b0;
    gd = {grant, deny};
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [1:0] gd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 status", int'({srwd, tb_sel, bp_level}), 0);
    check("R1 pulses", int'({grant, deny}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({grant, deny, srwd, tb_sel, bp_level}), 0);

    // R5..R9, R10: full sweep of level x direction x block
    for (int cfg = 0; cfg < 32; cfg++) begin
      int lvl = cfg % 16;
      bit tb  = (cfg >= 16);
      logic [5:0] sw = {1'b0, tb, 4'(lvl)};
      write_status(sw);
      check("R2 status load", int'({srwd, tb_sel, bp_level}), int'(sw));
      for (int blk = 0; blk < 512; blk++) begin
        logic [15:0] low = 16'((blk * 613 + cfg * 97) & 16'hFFFF);
        bit exp_d = want_deny(lvl, tb, blk);
        request({9'(blk), low}, gd);
        if (lvl == 0)       check("R5 level0", int'(gd), 2);
        else if (lvl >= 10) check("R8 all", int'(gd), 1);
        else if (tb)        check("R6 top window", int'(gd), exp_d ? 1 : 2);
        else                check("R7 bottom window", int'(gd), exp_d ? 1 : 2);
      end
      @(negedge clk);
      check("R9 single pulse", int'({grant, deny}), 0);
      check("R10 status kept", int'({srwd, tb_sel, bp_level}), int'(sw));
    end

    // R9: low address bits have no effect at a window edge
    write_status(6'b010011);  // top, level 3 -> blocks 508..511
    request({9'd507, 16'hFFFF}, gd); check("R9 low bits edge below", int'(gd), 2);
    request({9'd508, 16'h0000}, gd); check("R9 low bits edge at", int'(gd), 1);

    // R3: lock set, pin low, quad off -> refused
    write_status(6'b100011);
    check("R2 lock set", int'({srwd, tb_sel, bp_level}), 6'b100011);
    wp_n = 1'b0;
    write_status(6'b000000);
    check("R3 write refused", int'({srwd, tb_sel, bp_level}), 6'b100011);
    request({9'd1, 16'h0}, gd); check("R3 window kept", int'(gd), 1);

    // R4: quad mode bypasses the pin guard
    quad_mode = 1'b1;
    write_status(6'b100101);
    check("R4 quad write", int'({srwd, tb_sel, bp_level}), 6'b100101);
    quad_mode = 1'b0;
    write_status(6'b000001);
    check("R3 refused again", int'({srwd, tb_sel, bp_level}), 6'b100101);

    // R2: pin high with lock set -> accepted; lock clear with pin low -> accepted
    wp_n = 1'b1;
    write_status(6'b100000);
    check("R2 pin high", int'({srwd, tb_sel, bp_level}), 6'b100000);
    wp_n = 1'b0;
    write_status(6'b001010);
    check("R2 unlocked blocked pin", int'({srwd, tb_sel, bp_level}), 6'b100000);
    wp_n = 1'b1;
    write_status(6'b001010);
    wp_n = 1'b0;
    write_status(6'b000000);
    check("R2 lock clear pin low", int'({srwd, tb_sel, bp_level}), 0);
    wp_n = 1'b1;

    // R11: same-cycle write and request use old status
    write_status(6'b001111);
    @(negedge clk);
    pe_req = 1'b1; addr = {9'd0, 16'h0};
    sr_wr = 1'b1;  sr_wdata = 6'b000000;
    @(negedge clk);
    pe_req = 1'b0; sr_wr = 1'b0;
    check("R11 old status deny", int'({grant, deny}), 1);
    check("R11 write landed", int'({srwd, tb_sel, bp_level}), 0);
    request({9'd0, 16'h0}, gd); check("R11 new status grant", int'(gd), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule